// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Core with Selectable Deselect Timing

This block is the storage array and data path of a pipelined synchronous SRAM. Each word holds four 9-bit lanes. The depth is set by an address-width parameter. On every rising clock edge the block captures one command into an input stage: a read, a write or a deselect. A read returns its word through an output register one clock later. A write commits its selected lanes to the array on the following edge, with no external write strobe.

The data bus enable comes from a small driver state machine. The bench and the system see this enable as `dout_en`, and `dout` is forced to zero whenever it is low. A mode input picks single-cycle or dual-cycle deselect. In single-cycle mode the bus turns off on the first edge after a non-read is captured. In dual-cycle mode the driver holds the last read word for one more full cycle before it turns off.

The driver state machine has three states:
- DRV_OFF: the bus is idle.
- DRV_ON: a read word is being presented.
- DRV_HOLD: the extra cycle used in dual-cycle mode.

Its transitions are:
- OFF->ON, ON->ON and HOLD->ON: a read sits in the input stage.
- ON->HOLD: a non-read sits in the input stage and dual-cycle mode is selected.
- ON->OFF: a non-read sits in the input stage and single-cycle mode is selected.
- HOLD->OFF: a non-read sits in the input stage.
- OFF->OFF: no read is pending.

An asynchronous output-enable pin and a sleep input gate the bus directly. While sleep is high, every register is frozen and the array keeps its contents.

Top module: `psram_core`

## Requirements
- R1: After reset, `dout_en` is 0 and `dout` is all zeros.
- R2: The command is decoded as follows. `chip_sel` high with `all_wr` and `lane_wr_en` both low is a read. A read captured at edge k presents the addressed word on `dout`, with `dout_en` high, after edge k+1. This assumes `out_en` is 1 and `sleep` is 0.
- R3: The byte write is set by `lane_wr_en` high with `all_wr` low. It writes only the lanes whose `lane_sel` bit is 1. Lane i is bits 9i+8 down to 9i. All other lanes keep their old value.
- R4: `all_wr` high writes all four lanes, whatever the values of `lane_wr_en` and `lane_sel`.
- R5: A byte write with `lane_sel` equal to 0000 leaves the addressed word unchanged.
- R6: A read captured on the edge right after a write to the same address returns the newly written word.
- R7: In single-cycle mode (`dcd_mode`=0), a deselect captured at edge k turns off `dout_en` after edge k+1. A deselect is `chip_sel` low.
- R8: In dual-cycle mode (`dcd_mode`=1), a non-read that follows a read keeps `dout_en` high, with the last read word on `dout`, for one more cycle. `dout_en` then goes low after edge k+2.
- R9: `out_en` gates `dout_en` and `dout` without waiting for a clock edge.
- R10: While `sleep` is 1, `dout_en` is 0 and `dout` is zero. Commands are ignored, the array keeps its contents, and the pipeline resumes its held state once sleep is released.
- R11: A captured write turns off the bus with the same mode-dependent timing as a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline registers |
| chip_sel | input | 1 | Command present; low means deselect |
| all_wr | input | 1 | Write all four lanes |
| lane_wr_en | input | 1 | Byte-write enable, qualified by lane_sel |
| lane_sel | input | 4 | Per-lane write select, bit i controls lane i |
| addr | input | ADDR_W | Word address |
| wdata | input | 36 | Write word |
| dcd_mode | input | 1 | 0: single-cycle deselect, 1: dual-cycle deselect |
| out_en | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Low-power freeze, active high |
| dout | output | 36 | Read word, zero when not driven |
| dout_en | output | 1 | Data bus drive enable |

## Verification
A wrong driver state shows up at the ports as `dout_en` that is high or low one cycle off. The bench sees this on the first edge after the command that moves the state. In dual-cycle mode a missing HOLD shows as a one-cycle-short drive window right after the last read. Write-mask faults stay in the array and only become visible on the `dout` word two edges after a later read of that address. For this reason every write in the sequence is followed by a read-back, and each read-back compares all four lanes. A pipeline that fails to freeze during sleep shows as a wrong word, or a wrong enable, on the first cycle after sleep is released.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,
        DRV_ON   = 2'd1,
        DRV_HOLD = 2'd2
    } drv_e;

endpackage

// File: rtl/psram_cmd_reg.sv
module psram_cmd_reg
    import psram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic                    chip_sel,
    input  logic                    all_wr,
    input  logic                    lane_wr_en,
    input  logic [LANES-1:0]        lane_sel,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*BYTE_W-1:0] wdata,
    output cmd_e                    kind_q,
    output logic [ADDR_W-1:0]       addr_q,
    output logic [LANES-1:0]        mask_q,
    output logic [LANES*BYTE_W-1:0] wdata_q
);
    localparam int WORD_W = LANES * BYTE_W;

    logic [LANES-1:0] mask_d;
    cmd_e             kind_d;

    // Per-lane write select: global write overrides the lane controls.
    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign mask_d[g] = all_wr | (lane_wr_en & lane_sel[g]);
    end

    always_comb begin
        if (!chip_sel)                 kind_d = CMD_DESEL;
        else if (all_wr || lane_wr_en) kind_d = CMD_WRITE;
        else                           kind_d = CMD_READ;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= CMD_DESEL;
            addr_q  <= '0;
            mask_q  <= '0;
            wdata_q <= '0;
        end else if (!hold) begin
            kind_q  <= kind_d;
            addr_q  <= addr;
            mask_q  <= mask_d;
            wdata_q <= wdata;
        end
    end

    a_r4_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel && all_wr && !hold) |=> (kind_q == CMD_WRITE && mask_q == {LANES{1'b1}}))
        else $error("a_r4_global_all_lanes");

    a_r2_plain_read: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel && !all_wr && !lane_wr_en && !hold) |=> (kind_q == CMD_READ))
        else $error("a_r2_plain_read");

    a_r10_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(kind_q) && $stable(addr_q) && $stable(mask_q)))
        else $error("a_r10_cmd_frozen");

    logic unused_w;
    assign unused_w = ^wdata_q[WORD_W-1:0] & 1'b0;

endmodule

// File: rtl/psram_array.sv
module psram_array #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic                    wr_go,
    input  logic                    rd_go,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        mask,
    input  logic [LANES*BYTE_W-1:0] wdata,
    output logic [LANES*BYTE_W-1:0] rdata_q
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = LANES * BYTE_W;

    logic [WORD_W-1:0] rword;

    // One storage column per lane; a lane is written only when its mask bit is set.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_go && !hold && mask[g]) begin
                cells[addr] <= wdata[g*BYTE_W +: BYTE_W];
            end
        end

        assign rword[g*BYTE_W +: BYTE_W] = cells[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_go && !hold) begin
            rdata_q <= rword;
        end
    end

    a_r10_rdata_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(rdata_q))
        else $error("a_r10_rdata_frozen");

    a_r8_rdata_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rdata_q))
        else $error("a_r8_rdata_kept");

endmodule

// File: rtl/psram_drv_fsm.sv
module psram_drv_fsm
    import psram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic dcd_mode,
    input  logic rd_pending,
    output logic drive
);
    drv_e state_q;
    drv_e state_d;

    always_comb begin
        state_d = state_q;
        if (!hold) begin
            unique case (state_q)
                DRV_OFF:  state_d = rd_pending ? DRV_ON : DRV_OFF;
                DRV_ON:   state_d = rd_pending ? DRV_ON : (dcd_mode ? DRV_HOLD : DRV_OFF);
                DRV_HOLD: state_d = rd_pending ? DRV_ON : DRV_OFF;
                default:  state_d = DRV_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DRV_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            DRV_ON, DRV_HOLD: drive = 1'b1;
            default:          drive = 1'b0;
        endcase
    end

    a_r2_read_turns_on: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pending && !hold) |=> (state_q == DRV_ON))
        else $error("a_r2_read_turns_on");

    a_r7_single_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!dcd_mode && !hold && !rd_pending && state_q == DRV_ON) |=> (state_q == DRV_OFF))
        else $error("a_r7_single_off");

    a_r8_dual_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dcd_mode && !hold && !rd_pending && state_q == DRV_ON) |=> (state_q == DRV_HOLD))
        else $error("a_r8_dual_hold");

    a_r8_hold_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DRV_HOLD && !hold) |=> (state_q != DRV_HOLD))
        else $error("a_r8_hold_one_cycle");

    a_r10_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(state_q))
        else $error("a_r10_state_frozen");

endmodule

// File: rtl/psram_core.sv
module psram_core
    import psram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    chip_sel,
    input  logic                    all_wr,
    input  logic                    lane_wr_en,
    input  logic [LANES-1:0]        lane_sel,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*BYTE_W-1:0] wdata,
    input  logic                    dcd_mode,
    input  logic                    out_en,
    input  logic                    sleep,
    output logic [LANES*BYTE_W-1:0] dout,
    output logic                    dout_en
);
    localparam int WORD_W = LANES * BYTE_W;

    cmd_e              s1_kind;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_mask;
    logic [WORD_W-1:0] s1_wdata;
    logic [WORD_W-1:0] rdata_q;
    logic              drive;

    psram_cmd_reg #(.LANES(LANES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (sleep),
        .chip_sel   (chip_sel),
        .all_wr     (all_wr),
        .lane_wr_en (lane_wr_en),
        .lane_sel   (lane_sel),
        .addr       (addr),
        .wdata      (wdata),
        .kind_q     (s1_kind),
        .addr_q     (s1_addr),
        .mask_q     (s1_mask),
        .wdata_q    (s1_wdata)
    );

    psram_array #(.LANES(LANES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (sleep),
        .wr_go   (s1_kind == CMD_WRITE),
        .rd_go   (s1_kind == CMD_READ),
        .addr    (s1_addr),
        .mask    (s1_mask),
        .wdata   (s1_wdata),
        .rdata_q (rdata_q)
    );

    psram_drv_fsm u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (sleep),
        .dcd_mode   (dcd_mode),
        .rd_pending (s1_kind == CMD_READ),
        .drive      (drive)
    );

    // Asynchronous gating of the bus by the output-enable pin and sleep.
    assign dout_en = drive & out_en & ~sleep;
    assign dout    = dout_en ? rdata_q : '0;

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> !dout_en)
        else $error("a_r1_reset_quiet");

    a_r11_write_stops_read: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_kind == CMD_WRITE && !sleep) |=> $stable(rdata_q))
        else $error("a_r11_write_stops_read");

endmodule

// File: tb/psram_core_bench.sv
module psram_core_bench;
    localparam int PERIOD = 10;
    localparam int LANES  = 4;
    localparam int BYTE_W = 9;
    localparam int ADDR_W = 4;
    localparam int WORD_W = LANES * BYTE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chip_sel = 1'b0;
    logic              all_wr = 1'b0;
    logic              lane_wr_en = 1'b0;
    logic [LANES-1:0]  lane_sel = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [WORD_W-1:0] wdata = '0;
    logic              dcd_mode = 1'b0;
    logic              out_en = 1'b1;
    logic              sleep = 1'b0;
    logic [WORD_W-1:0] dout;
    logic              dout_en;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic              oe;
        logic [WORD_W-1:0] d;
        string             tag;
    } item_t;

    item_t sb[$];

    psram_core #(.LANES(LANES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_psram_core (
        .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .all_wr(all_wr),
        .lane_wr_en(lane_wr_en), .lane_sel(lane_sel), .addr(addr), .wdata(wdata),
        .dcd_mode(dcd_mode), .out_en(out_en), .sleep(sleep),
        .dout(dout), .dout_en(dout_en)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic act_oe, logic exp_oe,
                       logic [WORD_W-1:0] act_d, logic [WORD_W-1:0] exp_d);
        checks++;
        if (act_oe !== exp_oe || act_d !== exp_d) begin
            errors++;
            $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
                     tag, act_oe, act_d, exp_oe, exp_d);
        end
    endtask

    // Monitor: compares each cycle's outputs against the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                chk(it.tag, dout_en, it.oe, dout, it.d);
            end
        end
    end

    // Driver: applies one command and pushes the outputs expected after its edge.
    task automatic drive(logic cs, logic gw, logic bwe, logic [LANES-1:0] sel,
                         logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d, logic slp,
                         logic exp_oe, logic [WORD_W-1:0] exp_d, string tag);
        item_t it;
        @(negedge clk);
        chip_sel = cs; all_wr = gw; lane_wr_en = bwe; lane_sel = sel;
        addr = a; wdata = d; sleep = slp;
        it.oe = exp_oe; it.d = exp_d; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, logic eo, logic [WORD_W-1:0] ed, string tag);
        drive(1'b1, 1'b0, 1'b0, '0, a, '0, 1'b0, eo, ed, tag);
    endtask

    task automatic idle(logic eo, logic [WORD_W-1:0] ed, string tag);
        drive(1'b0, 1'b0, 1'b0, '0, '0, '0, 1'b0, eo, ed, tag);
    endtask

    task automatic drain;
        wait (sb.size() == 0);
        #1;
    endtask

    function automatic logic [WORD_W-1:0] merge(logic [WORD_W-1:0] old_w,
                                                 logic [WORD_W-1:0] new_w,
                                                 logic [LANES-1:0] sel);
        logic [WORD_W-1:0] r;
        r = old_w;
        for (int i = 0; i < LANES; i++)
            if (sel[i]) r[i*BYTE_W +: BYTE_W] = new_w[i*BYTE_W +: BYTE_W];
        return r;
    endfunction

    initial begin
        #(PERIOD*20000);
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [WORD_W-1:0] w1, d2, d3, m1, ones;
        w1   = 36'h123456789;
        d2   = 36'hFEDCBA987;
        d3   = 36'h0F0F0F0F0;
        ones = '1;
        m1   = merge(w1, d2, 4'b0101);

        repeat (3) @(posedge clk);
        #(PERIOD/4);
        chk("R1 reset", dout_en, 1'b0, dout, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Single-cycle deselect mode
        drive(1'b1, 1'b1, 1'b0, '0, 4'd1, w1, 1'b0, 1'b0, '0, "R4 global write");
        rd(4'd1, 1'b0, '0, "R11 write leaves bus off");
        rd(4'd1, 1'b1, w1, "R6 read after write");
        idle(1'b1, w1, "R2 read latency");
        idle(1'b0, '0, "R7 single-cycle off");
        drive(1'b1, 1'b0, 1'b1, 4'b0101, 4'd1, d2, 1'b0, 1'b0, '0, "R3 byte write");
        rd(4'd1, 1'b0, '0, "R11 byte write off");
        drive(1'b1, 1'b1, 1'b1, 4'b0000, 4'd2, d3, 1'b0, 1'b1, m1, "R3 lane merge");
        rd(4'd2, 1'b0, '0, "R11 write after read off");
        drive(1'b1, 1'b0, 1'b1, 4'b0000, 4'd1, ones, 1'b0, 1'b1, d3, "R4 override lanes");
        rd(4'd1, 1'b0, '0, "R11 empty write off");
        idle(1'b1, m1, "R5 empty mask unchanged");
        idle(1'b0, '0, "R7 single-cycle off");

        // Asynchronous output enable
        rd(4'd2, 1'b0, '0, "R2 read issue");
        rd(4'd2, 1'b1, d3, "R2 streaming read");
        drain();
        out_en = 1'b0;
        #1;
        chk("R9 async disable", dout_en, 1'b0, dout, '0);
        out_en = 1'b1;
        #1;
        chk("R9 async enable", dout_en, 1'b1, dout, d3);
        idle(1'b1, d3, "R2 second read");
        idle(1'b0, '0, "R7 single-cycle off");

        // Sleep
        rd(4'd1, 1'b0, '0, "R10 pre-sleep read");
        rd(4'd1, 1'b1, m1, "R10 pre-sleep data");
        drive(1'b1, 1'b1, 1'b0, '0, 4'd1, ones, 1'b1, 1'b0, '0, "R10 sleep write blocked");
        drive(1'b1, 1'b0, 1'b0, '0, 4'd2, '0, 1'b1, 1'b0, '0, "R10 sleep read blocked");
        idle(1'b1, m1, "R10 wake resumes pipeline");
        idle(1'b0, '0, "R7 single-cycle off");
        rd(4'd1, 1'b0, '0, "R10 read back");
        idle(1'b1, m1, "R10 contents kept");
        idle(1'b0, '0, "R7 single-cycle off");
        drain();

        // Dual-cycle deselect mode
        dcd_mode = 1'b1;
        rd(4'd2, 1'b0, '0, "R8 read issue");
        idle(1'b1, d3, "R8 data");
        idle(1'b1, d3, "R8 hold cycle");
        idle(1'b0, '0, "R8 off after hold");
        rd(4'd1, 1'b0, '0, "R8 read issue");
        drive(1'b1, 1'b1, 1'b0, '0, 4'd3, w1, 1'b0, 1'b1, m1, "R2 data during write");
        idle(1'b1, m1, "R11 dual-cycle write hold");
        rd(4'd3, 1'b0, '0, "R11 dual-cycle write off");
        idle(1'b1, w1, "R6 dual read back");
        idle(1'b1, w1, "R8 hold cycle");
        idle(1'b0, '0, "R8 off after hold");
        drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule